// File: doc/BRIEF.md
# Banked Pin Toggle Interrupt Detector

This block watches a set of general-purpose input pins, arranged in banks of equal width (two banks of eight by default). Each pin runs through a short chain of capture and synchronising registers. The synchronised value is then compared with its value one clock earlier. When a pin enabled in its bank's mask changes level, in either direction, the bank's sticky flag is set a fixed number of clocks after the pin moved.

Pins are sampled even when the surrounding device drives them as outputs. Software can therefore raise an interrupt by writing one of its own pins. Each flag stays set until its clear strobe is pulsed. A single interrupt request combines the flags that have their bank enable asserted.

Top module: `pin_change_irq`

## Requirements
- R1: After reset every flag and the interrupt request are 0, and all pipeline state is 0, so no toggle is seen on the first cycles after reset.
- R2: A rising change on an enabled pin sets its bank's flag on exactly the fourth rising clock edge after the change, counting the first edge that samples the new level as the first, with the default of two sampling stages. Before that edge the flag stays 0.
- R3: A falling change on an enabled pin sets its bank's flag with the same latency as a rising change.
- R4: A change on a pin whose mask bit is 0 (bit i of the mask enables pin i, where 1 means enabled) never sets a flag.
- R5: Pins 0 to 7 can only set flag bit 0, and pins 8 to 15 can only set flag bit 1. The mask bus uses the same bit positions as the pin bus.
- R6: A flag stays 1 until a clear strobe of 1 is presented on its bit. The flag then reads 0 after that clock edge.
- R7: When a set event and a clear strobe reach the same flag in the same cycle, the flag ends up 1.
- R8: The interrupt request is 1 exactly when some flag bit is 1 and the enable bit at the same position is 1.
- R9: Changing a mask bit while the pins stay steady does not set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 16 | Raw pin levels; bit i is pin i |
| pin_mask | input | 16 | Per-pin enable; bit i enables pin i |
| bank_en | input | 2 | Per-bank interrupt request enable |
| flag_clr | input | 2 | Per-bank clear strobe, active high |
| bank_flag | output | 2 | Sticky per-bank toggle flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default build: two banks of eight pins and two sampling stages. With these values the four-edge latency can be checked on exact cycles. Both banks can be driven at once, which shows that each bank only affects its own flag. A behavioural model keeps a history of the pin samples and predicts both flags and the request on every clock. It covers the same-cycle set and clear and the mask changes made while the pins are steady. It also covers a long random mix of toggles, masks, enables and clears.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    parameter int PCD_DEF_BANKS  = 2;
    parameter int PCD_DEF_WIDTH  = 8;
    parameter int PCD_DEF_STAGES = 2;

    typedef struct packed {
        logic set;
        logic flag;
    } pcd_flag_t;

endpackage

// File: rtl/pcd_pin_sync.sv
module pcd_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] smp_o,
    output logic [WIDTH-1:0] prev_o
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.chain[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.chain[i] = sync_q.chain[i-1];
        end
        sync_d.prev = sync_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign smp_o  = sync_q.chain[LAST];
    assign prev_o = sync_q.prev;

endmodule

// File: rtl/pcd_bank_flag.sv
module pcd_bank_flag
    import pcd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] smp_i,
    input  logic [WIDTH-1:0] prev_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic             clr_i,
    output logic             flag_o
);

    pcd_flag_t flag_d, flag_q;

    always_comb begin
        flag_d      = flag_q;
        flag_d.set  = |(mask_i & (smp_i ^ prev_i));
        flag_d.flag = (flag_q.flag & ~clr_i) | flag_q.set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q.flag;

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q.set && clr_i) |=> flag_o); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q.set && clr_i) |=> !flag_o); // R6
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o); // R6
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !flag_q.set) |=> !flag_o); // R4

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
    import pcd_pkg::*;
#(
    parameter int BANKS  = PCD_DEF_BANKS,
    parameter int WIDTH  = PCD_DEF_WIDTH,
    parameter int STAGES = PCD_DEF_STAGES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BANKS*WIDTH-1:0] pin_in,
    input  logic [BANKS*WIDTH-1:0] pin_mask,
    input  logic [BANKS-1:0]       bank_en,
    input  logic [BANKS-1:0]       flag_clr,
    output logic [BANKS-1:0]       bank_flag,
    output logic                   irq
);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [WIDTH-1:0] smp;
        logic [WIDTH-1:0] prev;

        pcd_pin_sync #(
            .WIDTH  (WIDTH),
            .STAGES (STAGES)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_in[b*WIDTH +: WIDTH]),
            .smp_o  (smp),
            .prev_o (prev)
        );

        pcd_bank_flag #(
            .WIDTH (WIDTH)
        ) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_i  (smp),
            .prev_i (prev),
            .mask_i (pin_mask[b*WIDTH +: WIDTH]),
            .clr_i  (flag_clr[b]),
            .flag_o (bank_flag[b])
        );
    end

    assign irq = |(bank_flag & bank_en);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en == '0) |-> !irq); // R8
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank_flag == '0)); // R1

endmodule

// File: tb/pin_change_irq_bench.sv
`timescale 1ns/1ps
module pin_change_irq_bench;

    localparam int NB = 2;
    localparam int W  = 8;
    localparam int ST = 2;
    localparam int N  = NB*W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_mask = '0;
    logic [NB-1:0] bank_en = '0;
    logic [NB-1:0] flag_clr = '0;
    logic [NB-1:0] bank_flag;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    pin_change_irq #(.BANKS(NB), .WIDTH(W), .STAGES(ST)) u_pin_change_irq (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_mask(pin_mask),
        .bank_en(bank_en), .flag_clr(flag_clr), .bank_flag(bank_flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: history of pin samples, one entry per edge
    logic [N-1:0]  hist[$];
    logic [NB-1:0] m_set, m_flag;

    initial begin
        for (int i = 0; i < ST+2; i++) hist.push_back('0);
        m_set = '0;
        m_flag = '0;
    end

    always @(posedge clk) begin
        logic [NB-1:0] nset;
        if (!rst_n) begin
            for (int i = 0; i < ST+2; i++) hist[i] = '0;
            m_set = '0;
            m_flag = '0;
        end else begin
            hist.push_front(pin_in);
            hist.delete(hist.size()-1);
            for (int b = 0; b < NB; b++) begin
                nset[b] = |(pin_mask[b*W +: W] & (hist[ST][b*W +: W] ^ hist[ST+1][b*W +: W]));
            end
            m_flag = (m_flag & ~flag_clr) | m_set;
            m_set  = nset;
        end
        #2;
        if (rst_n && !done) begin
            chk({phase, " model flags"}, int'(bank_flag), int'(m_flag));
            chk({phase, " model irq"}, int'(irq), int'(|(m_flag & bank_en)));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk) flag_clr = '1;
        @(negedge clk) flag_clr = '0;
    endtask

    initial begin
        // R1: reset state
        idle(3);
        chk("R1 flags in reset", int'(bank_flag), 0);
        chk("R1 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        idle(4);
        chk("R1 flags after reset", int'(bank_flag), 0);

        // R2: rising change, exact latency
        phase = "R2";
        pin_mask = '1;
        bank_en  = '1;
        idle(3);
        pin_in[0] = 1'b1;
        repeat (3) @(posedge clk);
        #2 chk("R2 flag0 before 4th edge", int'(bank_flag[0]), 0);
        @(posedge clk);
        #2 chk("R2 flag0 at 4th edge", int'(bank_flag[0]), 1);
        chk("R5 flag1 untouched by pin0", int'(bank_flag[1]), 0);
        chk("R8 irq with flag0 enabled", int'(irq), 1);

        // R6: sticky then cleared
        phase = "R6";
        idle(10);
        chk("R6 flag0 sticky", int'(bank_flag[0]), 1);
        clear_all();
        chk("R6 flag0 cleared", int'(bank_flag[0]), 0);

        // R3: falling change
        phase = "R3";
        @(negedge clk) pin_in[0] = 1'b0;
        repeat (3) @(posedge clk);
        #2 chk("R3 flag0 before 4th edge", int'(bank_flag[0]), 0);
        @(posedge clk);
        #2 chk("R3 flag0 at 4th edge", int'(bank_flag[0]), 1);
        clear_all();

        // R4: masked pin ignored
        phase = "R4";
        @(negedge clk) pin_mask[7:0] = 8'h01;
        @(negedge clk) pin_in[5] = 1'b1;
        idle(8);
        chk("R4 masked pin5 flag0", int'(bank_flag[0]), 0);

        // R9: mask change alone
        phase = "R9";
        @(negedge clk) pin_mask[7:0] = 8'hFF;
        idle(8);
        chk("R9 mask widen flag0", int'(bank_flag[0]), 0);

        // R5: bank separation
        phase = "R5";
        @(negedge clk) pin_in[12] = 1'b1;
        idle(6);
        chk("R5 pin12 sets flag1", int'(bank_flag[1]), 1);
        chk("R5 pin12 leaves flag0", int'(bank_flag[0]), 0);

        // R8: enable gating
        phase = "R8";
        @(negedge clk) bank_en = 2'b01;
        #1 chk("R8 irq with flag1 disabled", int'(irq), 0);
        @(negedge clk) bank_en = 2'b10;
        #1 chk("R8 irq with flag1 enabled", int'(irq), 1);
        clear_all();
        bank_en = '1;

        // R7: set and clear in same cycle
        phase = "R7";
        idle(2);
        @(negedge clk) begin flag_clr[0] = 1'b1; pin_in[1] = 1'b1; end
        repeat (4) @(posedge clk);
        #2 chk("R7 set beats clear", int'(bank_flag[0]), 1);
        @(posedge clk);
        #2 chk("R7 clear after set", int'(bank_flag[0]), 0);
        @(negedge clk) flag_clr = '0;

        // random mix compared against the model
        phase = "R2/R3/R4/R6/R7/R8/R9 random";
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 2) == 0) pin_in ^= N'(1) << $urandom_range(0, N-1);
            if ($urandom_range(0, 15) == 0) pin_mask = N'($urandom());
            if ($urandom_range(0, 7) == 0) bank_en = NB'($urandom());
            flag_clr = ($urandom_range(0, 5) == 0) ? NB'($urandom()) : '0;
        end
        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule